// File: doc/BRIEF.md
# Serial Peripheral Master with Receive-Fill Alarm

This block is a register-controlled serial peripheral (SPI) master that moves bytes between a transmit queue and a receive queue over a four-wire link. Software writes bytes into the transmit queue, and the block shifts each one out on `spi_mosi`. For every byte sent it captures one byte from `spi_miso` into the receive queue. Clock polarity, clock phase and bit order are programmable. The serial clock is the master clock divided by a programmable factor.

A frame is closed by a one-shot tag. Software sets the tag just before it writes the last byte of a frame. Chip select stays asserted across untagged bytes, including while the transmit queue runs dry. It is released once the tagged byte has finished shifting. A programmable idle gap then passes before the next frame starts.

The interrupt output reports receive-ready in one of two modes. In the first mode it fires as soon as any byte is waiting. In the alarm mode it fires once the free space in the receive queue drops to a programmed level. This lets software collect long transfers in blocks.

Top module: `spi_alarm_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `irq` is 0. The divider register (address 2) reads 0x0013 and the gap register (address 9) reads 0x0084. The status register (address 8) and the receive count (address 6) read 0.
- R2: The low byte N of the divider register sets the bit period to N+1 master clocks (N must be at least 1). The upper byte of that register is stored and read back unchanged, with no effect on the clock.
- R3: The control register (address 1) holds clock phase in bit 0 and clock polarity in bit 1. While `spi_cs_n` is high, `spi_sclk` equals the polarity bit. With phase 0, data is valid on the leading clock edge. With phase 1, data is valid on the trailing clock edge.
- R4: Control bit 2 set sends and receives the least significant bit first. When it is clear, the most significant bit goes first.
- R5: Each byte shifted out pushes exactly one byte, captured from `spi_miso`, into the receive queue. Reads of the data register (address 4) return received bytes in arrival order.
- R6: Writing 1 to bit 0 of the frame-end register (address 3) tags the next accepted data write. `spi_cs_n` rises after the tagged byte completes and stays low between untagged bytes.
- R7: Between a tagged byte and a waiting next byte, `spi_cs_n` stays high for exactly G+1 master clocks, where G is the gap register value.
- R8: Writing to the command register (address 0) acts on the value: 1 empties the receive queue and clears the underflow flag, 2 empties the transmit queue and clears the overflow flag and the tag, 3 enables shifting, 4 disables it. No byte starts while disabled.
- R9: With control bit 3 clear, receive-ready is "receive queue not empty". With it set, receive-ready is "free receive slots <= alarm register (address 5)". Status bit 0 shows receive-ready, and `irq` is receive-ready AND mask register (address 7) bit 0.
- R10: The receive count register (address 6) gives the number of bytes held in the receive queue.
- R11: A data write to a full transmit queue is dropped and sets status bit 1. A data read from an empty receive queue returns 0 and sets status bit 2. Both flags are sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | register address |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, valid in the cycle of the read |
| spi_sclk | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_cs_n | output | 1 | active-low chip select |
| irq | output | 1 | masked receive-ready interrupt |

## Verification
The bench builds the block with 8-entry queues instead of 512. With that depth, a ninth write fills the transmit queue to overflow, and five received bytes bring the free count down to an alarm level of 3. Both conditions are reached within a few hundred clocks. The divider is set to 3, so each byte takes 32 clocks and the clock-period and idle-gap measurements stay short. The serial input is looped back inverted from the output, so every received byte has a known expected value.

// File: rtl/spi_alarm_pkg.sv
package spi_alarm_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd2;
    localparam logic [ADDR_W-1:0] A_EOF   = 4'd3;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'd4;
    localparam logic [ADDR_W-1:0] A_ALARM = 4'd5;
    localparam logic [ADDR_W-1:0] A_RXCNT = 4'd6;
    localparam logic [ADDR_W-1:0] A_MASK  = 4'd7;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_GAP   = 4'd9;

    // command codes
    localparam logic [2:0] C_RST_RX  = 3'd1;
    localparam logic [2:0] C_RST_TX  = 3'd2;
    localparam logic [2:0] C_ENABLE  = 3'd3;
    localparam logic [2:0] C_DISABLE = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_HOLD, ST_GAP} sh_state_e;

    typedef struct packed {
        sh_state_e   st;
        logic [7:0]  cnt;
        logic [2:0]  bitn;
        logic [7:0]  tx;
        logic [7:0]  rx;
        logic        last;
        logic [15:0] gcnt;
    } sh_regs_t;

    typedef struct packed {
        logic        en;
        logic        cpha;
        logic        cpol;
        logic        lsb;
        logic        amode;
        logic        eof_tag;
        logic        mask;
        logic        ovf;
        logic        udf;
        logic [15:0] div;
        logic [15:0] alarm;
        logic [15:0] gap;
    } ctl_regs_t;
endpackage

// File: rtl/spi_alarm_fifo.sv
module spi_alarm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 512,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push) d.wr = step(q.wr);
            if (pop)  d.rd = step(q.rd);
            d.cnt = q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem[q.wr] <= wdata;
    end

    assign rdata = mem[q.rd];
    assign count = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/spi_alarm_shifter.sv
module spi_alarm_shifter
    import spi_alarm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        cpol,
    input  logic        cpha,
    input  logic        lsb,
    input  logic [7:0]  div,
    input  logic [15:0] gap,
    input  logic        tx_empty,
    input  logic [8:0]  tx_head,
    output logic        tx_pop,
    output logic        rx_push,
    output logic [7:0]  rx_byte,
    input  logic        miso,
    output logic        sclk,
    output logic        mosi,
    output logic        cs_n
);
    sh_regs_t q, d;
    logic [8:0] half;
    logic       start;
    logic       in_xfer;

    assign half    = ({1'b0, div} + 9'd1) >> 1;
    assign start   = en && !tx_empty;
    assign in_xfer = (q.st == ST_XFER);

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_byte = q.rx;
        case (q.st)
            ST_IDLE, ST_HOLD: begin
                if (start) begin
                    tx_pop = 1'b1;
                    d.st   = ST_XFER;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.tx   = tx_head[7:0];
                    d.last = tx_head[8];
                end
            end
            ST_XFER: begin
                if ({1'b0, q.cnt} == half)
                    d.rx = lsb ? {miso, q.rx[7:1]} : {q.rx[6:0], miso};
                if (q.cnt == div) begin
                    d.cnt = '0;
                    if (q.bitn == 3'd7) begin
                        rx_push = 1'b1;
                        rx_byte = d.rx;
                        if (q.last) begin
                            d.st   = (gap == '0) ? ST_IDLE : ST_GAP;
                            d.gcnt = gap;
                        end else if (start) begin
                            tx_pop = 1'b1;
                            d.bitn = '0;
                            d.tx   = tx_head[7:0];
                            d.last = tx_head[8];
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.tx   = lsb ? {1'b0, q.tx[7:1]} : {q.tx[6:0], 1'b0};
                    end
                end else begin
                    d.cnt = q.cnt + 8'd1;
                end
            end
            ST_GAP: begin
                if (q.gcnt <= 16'd1) d.st = ST_IDLE;
                else                 d.gcnt = q.gcnt - 16'd1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign cs_n = !(q.st == ST_XFER || q.st == ST_HOLD);
    assign sclk = in_xfer ? (cpol ^ (cpha ? ({1'b0, q.cnt} < half)
                                          : ({1'b0, q.cnt} >= half)))
                          : cpol;
    assign mosi = in_xfer ? (lsb ? q.tx[0] : q.tx[7]) : 1'b0;

    p_idle_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == cpol));
    p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && q.cnt == div && q.bitn == 3'd7 && q.last) |=> cs_n);
    p_pop_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
endmodule

// File: rtl/spi_alarm_master.sv
module spi_alarm_master
    import spi_alarm_pkg::*;
#(
    parameter int          FIFO_DEPTH = 512,
    parameter logic [15:0] DIV_RESET  = 16'h0013,
    parameter logic [15:0] GAP_RESET  = 16'h0084
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    ctl_regs_t q, d;
    logic          wr_en, rd_en;
    logic          tx_flush, rx_flush, tx_push, rx_pop;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [8:0]    tx_head;
    logic [7:0]    rx_head, sh_byte;
    logic [CW-1:0] tx_count, rx_count;
    logic          sh_pop, sh_push;
    logic [31:0]   rx_free;
    logic          rx_ready;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && !bus_wr;
    assign tx_push = wr_en && (bus_addr == A_DATA) && !tx_full;
    assign rx_pop  = rd_en && (bus_addr == A_DATA) && !rx_empty;

    always_comb begin
        d        = q;
        tx_flush = 1'b0;
        rx_flush = 1'b0;
        if (wr_en) begin
            case (bus_addr)
                A_CMD: begin
                    case (bus_wdata[2:0])
                        C_RST_RX:  begin rx_flush = 1'b1; d.udf = 1'b0; end
                        C_RST_TX:  begin tx_flush = 1'b1; d.ovf = 1'b0; d.eof_tag = 1'b0; end
                        C_ENABLE:  d.en = 1'b1;
                        C_DISABLE: d.en = 1'b0;
                        default:   ;
                    endcase
                end
                A_CTRL: begin
                    d.cpha  = bus_wdata[0];
                    d.cpol  = bus_wdata[1];
                    d.lsb   = bus_wdata[2];
                    d.amode = bus_wdata[3];
                end
                A_DIV:   d.div     = bus_wdata;
                A_EOF:   d.eof_tag = bus_wdata[0];
                A_DATA: begin
                    if (tx_full) d.ovf     = 1'b1;
                    else         d.eof_tag = 1'b0;
                end
                A_ALARM: d.alarm = bus_wdata;
                A_MASK:  d.mask  = bus_wdata[0];
                A_GAP:   d.gap   = bus_wdata;
                default: ;
            endcase
        end
        if (rd_en && (bus_addr == A_DATA) && rx_empty) d.udf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{div: DIV_RESET, gap: GAP_RESET, default: '0};
        else        q <= d;
    end

    spi_alarm_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata({q.eof_tag, bus_wdata[7:0]}),
        .pop(sh_pop), .rdata(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    spi_alarm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .push(sh_push && !rx_full), .wdata(sh_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    spi_alarm_shifter shifter_i (
        .clk(clk), .rst_n(rst_n), .en(q.en),
        .cpol(q.cpol), .cpha(q.cpha), .lsb(q.lsb),
        .div(q.div[7:0]), .gap(q.gap),
        .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(sh_pop),
        .rx_push(sh_push), .rx_byte(sh_byte),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n)
    );

    assign rx_free  = 32'(FIFO_DEPTH) - 32'(rx_count);
    assign rx_ready = q.amode ? (rx_free <= {16'd0, q.alarm}) : !rx_empty;
    assign irq      = rx_ready && q.mask;

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {12'd0, q.amode, q.lsb, q.cpol, q.cpha};
            A_DIV:   bus_rdata = q.div;
            A_EOF:   bus_rdata = {15'd0, q.eof_tag};
            A_DATA:  bus_rdata = rx_empty ? '0 : {8'd0, rx_head};
            A_ALARM: bus_rdata = q.alarm;
            A_RXCNT: bus_rdata = 16'(rx_count);
            A_MASK:  bus_rdata = {15'd0, q.mask};
            A_STAT:  bus_rdata = {13'd0, q.udf, q.ovf, rx_ready};
            A_GAP:   bus_rdata = q.gap;
            default: bus_rdata = '0;
        endcase
    end

    p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_DATA && tx_full) |=> q.ovf);
    p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == A_DATA && rx_empty) |=> q.udf);
    p_ready_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.amode && rx_empty) |-> !irq);
    p_idle_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && spi_cs_n) |=> spi_cs_n);
endmodule

// File: tb/spi_alarm_master_tb_top.sv
module spi_alarm_master_tb_top;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, mosi, miso, cs_n, irq;

    always #5 clk = ~clk;
    assign miso = ~mosi;

    spi_alarm_master #(.FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso),
        .spi_cs_n(cs_n), .irq(irq)
    );

    int checks = 0, errors = 0;
    logic m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0;
    logic [7:0] exp_q[$];
    int bytes_seen = 0, frames = 0, last_run = 0, run = 0;
    int cyc = 0, last_edge_cyc = 0, last_edge_gap = 0, nb = 0;
    logic [7:0] acc = '0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 v = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic set_ctrl(input logic cpha, input logic cpol, input logic lsb, input logic amode);
        wr(4'd1, {12'd0, amode, lsb, cpol, cpha});
        m_cpha = cpha; m_cpol = cpol; m_lsb = lsb;
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        if (last) wr(4'd3, 16'd1);
        wr(4'd4, {8'd0, b});
        exp_q.push_back(b);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (exp_q.size() != 0 || !cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // reference monitor: samples the serial link on the edges the mode selects
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cs_n) check("R3 idle clock level", sclk, m_cpol);
            if (!cs_n && sclk != prev_sclk &&
                (m_cpha ? (sclk == m_cpol) : (sclk != m_cpol))) begin
                if (nb > 0) last_edge_gap = cyc - last_edge_cyc;
                last_edge_cyc = cyc;
                acc = m_lsb ? {mosi, acc[7:1]} : {acc[6:0], mosi};
                nb++;
                if (nb == 8) begin
                    nb = 0;
                    bytes_seen++;
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected byte on link", acc, 32'hFFFF);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        check("R4 serial byte and bit order", acc, e);
                    end
                end
            end
            if (cs_n) begin
                nb = 0;
                run++;
            end else if (prev_cs) begin
                last_run = run;
                run = 0;
                frames++;
            end
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", cs_n, 1);
        check("R1 sclk", sclk, 0);
        check("R1 irq", irq, 0);
        rd(4'd2, v); check("R1 divider reset", v, 16'h0013);
        rd(4'd9, v); check("R1 gap reset", v, 16'h0084);
        rd(4'd8, v); check("R1 status reset", v, 0);
        rd(4'd6, v); check("R1 rx count reset", v, 0);

        // mode 0, MSB first, two frames
        wr(4'd2, 16'h5A03);
        rd(4'd2, v); check("R2 upper byte kept", v, 16'h5A03);
        wr(4'd9, 16'd3);
        wr(4'd7, 16'd1);
        set_ctrl(0, 0, 0, 0);
        wr(4'd0, 16'd3);
        send(8'hA5, 0); send(8'h3C, 1); send(8'h81, 1);
        wait_idle();
        check("R5 bytes shifted", bytes_seen, 3);
        check("R2 bit period", last_edge_gap, 4);
        check("R7 idle gap length", last_run, 4);
        check("R6 frame count", frames, 2);
        rd(4'd6, v); check("R10 rx count", v, 3);
        check("R9 data-ready irq", irq, 1);
        rd(4'd4, v); check("R5 rx byte 0", v, 16'h005A);
        rd(4'd4, v); check("R5 rx byte 1", v, 16'h00C3);
        rd(4'd4, v); check("R5 rx byte 2", v, 16'h007E);
        @(negedge clk); check("R9 irq clears when empty", irq, 0);
        rd(4'd4, v); check("R11 empty read value", v, 0);
        rd(4'd8, v); check("R11 underflow flag", v, 16'h0004);
        wr(4'd0, 16'd1);
        rd(4'd8, v); check("R8 rx reset clears underflow", v, 0);

        // mode 3, LSB first
        set_ctrl(1, 1, 1, 0);
        send(8'h12, 0); send(8'hF0, 1);
        wait_idle();
        check("R6 frame count mode 3", frames, 3);
        rd(4'd4, v); check("R5 rx byte lsb 0", v, 16'h00ED);
        rd(4'd4, v); check("R5 rx byte lsb 1", v, 16'h000F);

        // alarm mode: fire when free slots <= 3
        wr(4'd5, 16'd3);
        set_ctrl(0, 1, 0, 1);
        send(8'h01, 0); send(8'h02, 0); send(8'h04, 0); send(8'h08, 1);
        wait_idle();
        rd(4'd6, v); check("R10 rx count four", v, 4);
        check("R9 alarm not reached", irq, 0);
        send(8'h55, 1);
        wait_idle();
        check("R9 alarm reached", irq, 1);
        wr(4'd7, 16'd0);
        @(negedge clk); check("R9 masked irq", irq, 0);
        rd(4'd8, v); check("R9 status shows ready", v, 16'h0001);
        wr(4'd0, 16'd1);
        rd(4'd6, v); check("R8 rx reset empties", v, 0);
        wr(4'd7, 16'd1);
        @(negedge clk); check("R9 alarm idle after flush", irq, 0);

        // disabled: fill transmit queue past full
        wr(4'd0, 16'd4);
        for (int i = 0; i < DEPTH + 1; i++) wr(4'd4, 16'(i));
        repeat (100) @(negedge clk);
        check("R8 disabled no shifting", frames, 5);
        rd(4'd8, v); check("R11 overflow flag", v, 16'h0002);
        wr(4'd0, 16'd2);
        rd(4'd8, v); check("R8 tx reset clears overflow", v, 0);
        wr(4'd0, 16'd3);
        repeat (100) @(negedge clk);
        check("R8 flushed bytes not sent", frames, 5);
        send(8'h6E, 1);
        wait_idle();
        check("R5 total bytes", bytes_seen, 11);
        rd(4'd4, v); check("R5 rx after flush", v, 16'h0091);
        check("R4 no byte outstanding", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule